// File: doc/BRIEF.md
# Memory self-test pattern filler

This block is a self-test engine for an 8 KB byte-wide dual-port buffer RAM. Once started, it sweeps every address from the bottom of the buffer to the top and writes one generated byte per clock. It adds each byte to a running 16-bit checksum as it writes, so the checksum is ready as soon as the last byte is in. A host can then read the buffer back through some other path, recompute the checksum and compare the two. If they differ, the memory is suspect.

There are three ways to generate the bytes:
- a pseudo-random stream from an 8-bit LFSR, seeded from the seed register;
- the low byte of each address;
- a rotating pattern that starts at the seed and rotates left by a programmed amount at each new address. A rotation of one on 55h gives a checkerboard.

The seed register works as the generator state. After a random or rotating fill it holds the final state. A port-select bit picks which of the two RAM write ports the engine uses, so both ports can be exercised. The start bit clears itself at the end of a pass. Writing it to zero during a pass cancels the pass.

Top module: `mem_bist_filler`

## Requirements
- R1: Starting a pass writes addresses 0 to DEPTH-1 (default 8192) in ascending order, one byte per clock. The first write is in the cycle after the start write, and there are exactly DEPTH writes.
- R2: In mode 00 (random), each byte equals the current LFSR state. After each write the state steps once: shift left, and the new bit 0 is the XOR of bits 7, 5, 4 and 3 (polynomial x^8+x^6+x^5+x^4+1).
- R3: At the end of a random or rotating pass, the seed output holds the final generator state. A zero seed in random mode writes only zeros and leaves the seed at zero. Repeating a seed reproduces the same checksum.
- R4: In mode 01 (address), each location receives the low 8 bits of its own address. Mode 11 behaves exactly like mode 01.
- R5: An address-mode pass over the full default buffer yields checksum F807h.
- R6: In mode 10 (rotate), location 0 receives the seed. Each later location receives the previous byte rotated left by the 3-bit shift amount, with bits leaving bit 7 re-entering at bit 0.
- R7: The checksum is the ones-complement of the ones-complement sum (end-around carry) of 16-bit words. Each word takes the even-address byte as its high byte and the next odd-address byte as its low byte.
- R8: done_o pulses for exactly one cycle, in the cycle after the final write. busy_o falls in that same cycle, and csum_o holds the new checksum from that cycle on.
- R9: Writing the control with start=0 during a pass stops it at the next edge. busy_o falls, done_o stays low, writes stop, and the seed holds the state reached after the writes already made.
- R10: psel_i=0 writes through port A only and psel_i=1 through port B only. A write enable is high exactly while busy_o is high.
- R11: Seed writes and control writes with start=1 are ignored while a pass runs. Mode, shift, port and seed stay as they were at the start.
- R12: After reset, busy_o, done_o and both write enables are low, and csum_o and seed_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_start_i | input | 1 | Start bit value written with ctl_wr_i (1 starts, 0 cancels) |
| mode_i | input | 2 | Fill mode: 00 random, 01 address, 10 rotate, 11 address |
| shift_i | input | 3 | Rotate amount per address in rotate mode |
| psel_i | input | 1 | RAM port select: 0 port A, 1 port B |
| seed_wr_i | input | 1 | Seed register write strobe |
| seed_i | input | 8 | Seed value written with seed_wr_i |
| busy_o | output | 1 | Start bit readback; high while a pass runs |
| done_o | output | 1 | One-cycle pulse when the checksum becomes valid |
| we_a_o | output | 1 | Write enable, RAM port A |
| we_b_o | output | 1 | Write enable, RAM port B |
| waddr_o | output | 13 | Write address (shared by both ports) |
| wdata_o | output | 8 | Write data (shared by both ports) |
| csum_o | output | 16 | Checksum of the last completed pass |
| seed_o | output | 8 | Seed register / generator state |

## Verification
The start write is captured at the next edge. The write to address k is then visible from the (k+1)-th falling edge after the start was driven, and done_o and the checksum appear at falling edge DEPTH+1. The bench drives every input on a falling edge and counts falling edges to sample done_o at exactly that point, and checks that it was low one edge earlier. A model RAM captures each write at the rising edge. For a cancel driven n falling edges after the start, the bench expects exactly n writes and a seed advanced n steps, and checks busy_o one falling edge later.

// File: rtl/bist_pkg.sv
package bist_pkg;
  typedef enum logic [1:0] {
    FILL_RAND = 2'b00,
    FILL_ADDR = 2'b01,
    FILL_ROT  = 2'b10,
    FILL_RSVD = 2'b11
  } fill_mode_e;

  // Fibonacci step, taps x^8+x^6+x^5+x^4+1
  function automatic logic [7:0] lfsr_step(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input logic [2:0] n);
    logic [15:0] w;
    w = {v, v} << n;
    return w[15:8];
  endfunction
endpackage

// File: rtl/bist_ctrl.sv
module bist_ctrl
  import bist_pkg::*;
#(
  parameter int DEPTH  = 8192,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic              ctl_start_i,
  input  logic [1:0]        mode_i,
  input  logic [2:0]        shift_i,
  input  logic              psel_i,
  output logic              busy_o,
  output logic              start_o,
  output logic              fin_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o,
  output fill_mode_e        mode_o,
  output logic [2:0]        shift_o,
  output logic              psel_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic busy_q, done_q, cancel;
  logic [ADDR_W-1:0] addr_q;

  assign start_o = !busy_q && ctl_wr_i && ctl_start_i;
  assign cancel  = busy_q && ctl_wr_i && !ctl_start_i;
  assign fin_o   = busy_q && !cancel && (addr_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      mode_o  <= FILL_RAND;
      shift_o <= '0;
      psel_o  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_o) begin
        busy_q  <= 1'b1;
        addr_q  <= '0;
        mode_o  <= fill_mode_e'(mode_i);
        shift_o <= shift_i;
        psel_o  <= psel_i;
      end else if (busy_q) begin
        if (cancel) begin
          busy_q <= 1'b0;
        end else if (fin_o) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          addr_q <= addr_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/bist_pattern.sv
module bist_pattern
  import bist_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       seed_wr_i,
  input  logic [7:0] seed_i,
  input  logic       busy_i,
  input  fill_mode_e mode_i,
  input  logic [2:0] shift_i,
  input  logic [7:0] addr_lo_i,
  output logic [7:0] data_o,
  output logic [7:0] seed_o
);
  logic [7:0] state_q, state_d;

  always_comb begin
    unique case (mode_i)
      FILL_RAND: begin data_o = state_q;   state_d = lfsr_step(state_q);       end
      FILL_ROT:  begin data_o = state_q;   state_d = rotl8(state_q, shift_i);  end
      default:   begin data_o = addr_lo_i; state_d = state_q;                  end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             state_q <= '0;
    else if (busy_i)         state_q <= state_d;   // host writes ignored while busy
    else if (seed_wr_i)      state_q <= seed_i;
  end

  assign seed_o = state_q;
endmodule

// File: rtl/bist_csum.sv
module bist_csum (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        acc_i,
  input  logic        fin_i,
  input  logic        odd_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] csum_o
);
  logic [15:0] sum_q, word, sum_d;
  logic [16:0] raw;

  always_comb begin
    word  = odd_i ? {8'h00, byte_i} : {byte_i, 8'h00};
    raw   = {1'b0, sum_q} + {1'b0, word};
    sum_d = raw[15:0] + {15'd0, raw[16]};   // end-around carry
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      csum_o <= '0;
    end else begin
      if (clr_i)      sum_q <= '0;
      else if (acc_i) sum_q <= sum_d;
      if (fin_i)      csum_o <= ~sum_d;
    end
  end
endmodule

// File: rtl/mem_bist_filler.sv
module mem_bist_filler
  import bist_pkg::*;
#(
  parameter int DEPTH  = 8192,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic              ctl_start_i,
  input  logic [1:0]        mode_i,
  input  logic [2:0]        shift_i,
  input  logic              psel_i,
  input  logic              seed_wr_i,
  input  logic [7:0]        seed_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              we_a_o,
  output logic              we_b_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [7:0]        wdata_o,
  output logic [15:0]       csum_o,
  output logic [7:0]        seed_o
);
  fill_mode_e  mode_q;
  logic [2:0]  shift_q;
  logic        psel_q, start, fin, busy;
  logic [ADDR_W-1:0] addr;

  bist_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .ctl_wr_i, .ctl_start_i, .mode_i, .shift_i, .psel_i,
    .busy_o(busy), .start_o(start), .fin_o(fin), .done_o(done_o),
    .addr_o(addr), .mode_o(mode_q), .shift_o(shift_q), .psel_o(psel_q)
  );

  bist_pattern u_pat (
    .clk_i, .rst_ni, .seed_wr_i, .seed_i, .busy_i(busy),
    .mode_i(mode_q), .shift_i(shift_q), .addr_lo_i(addr[7:0]),
    .data_o(wdata_o), .seed_o(seed_o)
  );

  bist_csum u_csum (
    .clk_i, .rst_ni, .clr_i(start), .acc_i(busy), .fin_i(fin),
    .odd_i(addr[0]), .byte_i(wdata_o), .csum_o(csum_o)
  );

  assign busy_o  = busy;
  assign waddr_o = addr;
  assign we_a_o  = busy && !psel_q;
  assign we_b_o  = busy && psel_q;
endmodule

// File: rtl/mem_bist_filler_chk.sv
module mem_bist_filler_chk
  import bist_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              we_a_o,
  input logic              we_b_o,
  input logic [ADDR_W-1:0] waddr_o,
  input logic [7:0]        wdata_o,
  input logic [7:0]        seed_o,
  input logic              seed_wr_i,
  input fill_mode_e        mode_q,
  input logic [2:0]        shift_q
);
  p_one_port_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({we_a_o, we_b_o}));
  p_we_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (we_a_o || we_b_o));
  p_addr_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> waddr_o == '0);
  p_addr_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> waddr_o == ADDR_W'($past(waddr_o) + 1'b1));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o) && $past(waddr_o) == '1);
  p_addr_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (mode_q == FILL_ADDR || mode_q == FILL_RSVD) |-> wdata_o == waddr_o[7:0]);
  p_rot_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && mode_q == FILL_ROT |-> wdata_o == rotl8($past(wdata_o), shift_q));
  p_lfsr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && mode_q == FILL_RAND |-> wdata_o == lfsr_step($past(wdata_o)));
  p_seed_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !$past(busy_o) && !$past(seed_wr_i) |-> $stable(seed_o));
endmodule

bind mem_bist_filler mem_bist_filler_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .we_a_o(we_a_o), .we_b_o(we_b_o), .waddr_o(waddr_o), .wdata_o(wdata_o),
  .seed_o(seed_o), .seed_wr_i(seed_wr_i), .mode_q(mode_q), .shift_q(shift_q)
);

// File: tb/tb_mem_bist_filler.sv
module tb_mem_bist_filler;
  localparam int DEPTH = 8192;
  localparam int AW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, ctl_start = 0, psel = 0, seed_wr = 0;
  logic [1:0] mode = 0;
  logic [2:0] shift = 0;
  logic [7:0] seed_in = 0;
  logic busy, done, we_a, we_b;
  logic [AW-1:0] waddr;
  logic [7:0] wdata, seed_out;
  logic [15:0] csum;

  int nchk = 0, nfail = 0, wcnt = 0, port_err = 0;
  logic cur_psel = 0;
  logic [7:0] mem [DEPTH];
  logic [7:0] exp_mem [DEPTH];
  logic [7:0] exp_seed;

  always #4 clk = ~clk;

  mem_bist_filler dut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_wr_i(ctl_wr), .ctl_start_i(ctl_start),
    .mode_i(mode), .shift_i(shift), .psel_i(psel), .seed_wr_i(seed_wr), .seed_i(seed_in),
    .busy_o(busy), .done_o(done), .we_a_o(we_a), .we_b_o(we_b), .waddr_o(waddr),
    .wdata_o(wdata), .csum_o(csum), .seed_o(seed_out)
  );

  always @(posedge clk) begin
    if (we_a || we_b) begin
      mem[waddr] <= wdata;
      wcnt++;
      if ((we_a && we_b) || (we_b != cur_psel)) port_err++;
    end
  end

  function automatic logic [7:0] m_lfsr(input logic [7:0] s);
    logic fb;
    fb = s[7] ^ s[5] ^ s[4] ^ s[3];
    return {s[6:0], fb};
  endfunction

  function automatic logic [7:0] m_rotl(input logic [7:0] v, input int n);
    logic [7:0] r;
    r = v;
    for (int i = 0; i < n; i++) r = {r[6:0], r[7]};
    return r;
  endfunction

  function automatic logic [15:0] m_csum();
    int unsigned tot;
    tot = 0;
    for (int w = 0; w < DEPTH / 2; w++) tot += {16'd0, mem[2*w], mem[2*w+1]};
    while (tot > 32'hFFFF) tot = (tot & 32'hFFFF) + (tot >> 16);
    return ~tot[15:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build_exp(input logic [1:0] md, input logic [2:0] sh, input logic [7:0] sd);
    logic [7:0] s;
    s = sd;
    for (int a = 0; a < DEPTH; a++) begin
      case (md)
        2'b00: begin exp_mem[a] = s; s = m_lfsr(s); end
        2'b10: begin exp_mem[a] = s; s = m_rotl(s, int'(sh)); end
        default: exp_mem[a] = a[7:0];
      endcase
    end
    exp_seed = s;
  endtask

  task automatic kick(input logic [1:0] md, input logic [2:0] sh, input logic ps, input logic [7:0] sd);
    @(negedge clk);
    seed_wr = 1; seed_in = sd;
    @(negedge clk);
    seed_wr = 0;
    for (int a = 0; a < DEPTH; a++) mem[a] = 8'hEE;
    wcnt = 0; port_err = 0; cur_psel = ps;
    ctl_wr = 1; ctl_start = 1; mode = md; shift = sh; psel = ps;
  endtask

  // full pass; inject != 0 tries to disturb the run while busy (R11)
  task automatic run_pass(input logic [1:0] md, input logic [2:0] sh, input logic ps,
                          input logic [7:0] sd, input bit inject, output logic [15:0] cs);
    int done_at, done_cnt, bad;
    build_exp(md, sh, sd);
    kick(md, sh, ps, sd);
    done_at = -1; done_cnt = 0;
    for (int n = 1; n <= DEPTH + 3; n++) begin
      @(negedge clk);
      ctl_wr = 0; seed_wr = 0;
      if (n == 1) chk("R1 busy after start", busy, 1);
      if (inject && n == 40) begin
        seed_wr = 1; seed_in = ~sd; ctl_wr = 1; ctl_start = 1;
        mode = md ^ 2'b11; shift = sh + 3'd1; psel = ~ps;
      end
      if (done) begin done_cnt++; if (done_at < 0) done_at = n; end
    end
    chk("R8 done position", done_at, DEPTH + 1);
    chk("R8 single done pulse", done_cnt, 1);
    chk("R8 busy cleared", busy, 0);
    chk("R1 write count", wcnt, DEPTH);
    chk("R10 port usage", port_err, 0);
    bad = 0;
    for (int a = 0; a < DEPTH; a++) if (mem[a] !== exp_mem[a]) bad++;
    chk(md == 2'b00 ? "R2 random data" : md == 2'b10 ? "R6 rotate data" : "R4 address data", bad, 0);
    chk("R7 checksum", csum, m_csum());
    chk("R3 seed writeback", seed_out, (md == 2'b00 || md == 2'b10) ? exp_seed : sd);
    cs = csum;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] c1, c2;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R12 busy", busy, 0);
    chk("R12 done", done, 0);
    chk("R12 we", {we_a, we_b}, 0);
    chk("R12 csum", csum, 0);
    chk("R12 seed", seed_out, 0);
    rst_n = 1;
    @(negedge clk);

    run_pass(2'b00, 3'd0, 1'b0, 8'hA5, 0, c1);
    run_pass(2'b00, 3'd0, 1'b1, 8'h00, 0, c2);
    chk("R3 zero seed stays zero", seed_out, 0);
    chk("R3 zero stream checksum", c2, 16'hFFFF);
    run_pass(2'b00, 3'd0, 1'b1, 8'hA5, 0, c2);
    chk("R3 repeat seed checksum", c2, c1);
    run_pass(2'b01, 3'd0, 1'b1, 8'h3C, 0, c1);
    chk("R5 address checksum", c1, 16'hF807);
    run_pass(2'b11, 3'd0, 1'b0, 8'h11, 0, c1);
    chk("R4 reserved mode as address", c1, 16'hF807);
    run_pass(2'b10, 3'd1, 1'b0, 8'h55, 0, c1);
    run_pass(2'b10, 3'd3, 1'b1, 8'h81, 1, c1);  // R11 injected writes ignored
    for (int k = 0; k < 3; k++) begin
      logic [1:0] md; logic [2:0] sh; logic ps; logic [7:0] sd;
      md = 2'($urandom_range(0, 3)); sh = 3'($urandom_range(0, 7));
      ps = 1'($urandom_range(0, 1)); sd = 8'($urandom_range(1, 255));
      run_pass(md, sh, ps, sd, 0, c1);
    end

    // R9 cancel after a known number of writes
    begin
      int n_cx;
      logic [7:0] s;
      logic [15:0] c_old;
      n_cx = 100;
      c_old = csum;
      kick(2'b00, 3'd0, 1'b0, 8'h5A);
      repeat (n_cx) begin @(negedge clk); ctl_wr = 0; end
      ctl_wr = 1; ctl_start = 0;
      @(negedge clk);
      ctl_wr = 0;
      chk("R9 busy after cancel", busy, 0);
      chk("R9 no done on cancel", done, 0);
      repeat (5) @(negedge clk);
      chk("R9 writes stop", wcnt, n_cx);
      chk("R9 csum unchanged", csum, c_old);
      s = 8'h5A;
      for (int i = 0; i < n_cx; i++) s = m_lfsr(s);
      chk("R9 seed after cancel", seed_out, s);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule